// File: doc/BRIEF.md
# Link Training Register Write Formatter

This block turns one link-training request into a single burst of register bytes for a sideband register channel to the display sink. A request carries a pattern byte, four lane-setting bytes, an active lane count and a request kind. The block works out the start address, the burst length and the byte order. It then sends the bytes over a valid/ready stream, with the address and length held beside every byte. When the transport returns its completion, the block compares the number of acknowledged bytes with the length it sent and reports the result.

A set-pattern request writes the pattern register and the lane-setting registers that follow it in a single contiguous burst. When the pattern field of the pattern byte selects "training off", only the pattern byte is sent. An update-lanes request writes only the lane-setting registers. A clear-lanes flag gives the restart form of set-pattern, in which every lane byte is sent as zero. The block takes one request at a time and shows `busy` until it has reported the outcome.

States: `ST_IDLE` (ready for a request), `ST_SEND` (streaming bytes), `ST_WAIT` (waiting for the completion) and `ST_REPORT` (one-cycle outcome). Transitions:
- `ST_IDLE` goes to `ST_SEND` when a request is accepted.
- `ST_SEND` goes to `ST_WAIT` when the last byte is handed over.
- `ST_WAIT` goes to `ST_REPORT` when a completion arrives.
- `ST_REPORT` always goes back to `ST_IDLE`.

Top module: `train_wr_fmt`

## Requirements
- R1: After reset, `busy`=0, `req_ready`=1, `out_valid`=0 and `done_valid`=0.
- R2: A set-pattern request (`req_kind`=0) whose pattern field is non-zero gives a burst with `out_addr`=PAT_ADDR (0x102 by default) and `out_len`=lane count+1. The bytes are the pattern byte first, then lane bytes 0 up to count-1, where lane i is `req_lanes[8*i+7:8*i]`.
- R3: The pattern field is `req_pattern[1:0]`, or `req_pattern[3:0]` when `req_four_pat`=1. When that field is zero, a set-pattern burst has `out_len`=1 and carries only the pattern byte. Bits above the field, such as the scrambling-off flag in bit 5, take no part in this decision.
- R4: An update-lanes request (`req_kind`=1) gives `out_addr`=PAT_ADDR+1 and `out_len`=lane count, and carries lane bytes 0 up to count-1 in order.
- R5: With `req_clear`=1, a set-pattern burst sends every lane byte as 0x00. For update-lanes, `req_clear` has no effect.
- R6: After the completion, `done_valid` pulses for exactly one cycle. `done_ok`=1 only if `cpl_count` equals the length of the burst.
- R7: `req_ready` is 0 while busy. A request presented while busy is ignored, and no bytes are streamed outside a burst.
- R8: While `out_valid`=1 and `out_ready`=0, the outputs `out_data`, `out_last`, `out_addr` and `out_len` stay unchanged. `out_last` is 1 on the final byte only.
- R9: `busy` rises in the cycle after a request is accepted and stays high through the cycle in which `done_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_kind | input | 1 | 0 = set-pattern, 1 = update-lanes |
| req_clear | input | 1 | Send zero lane bytes (set-pattern only) |
| req_four_pat | input | 1 | Pattern field is 4 bits wide instead of 2 |
| req_pattern | input | 8 | Pattern byte |
| req_lanes | input | 32 | Lane bytes, lane i in bits 8*i+7:8*i |
| req_lane_cnt | input | 3 | Active lanes, 1 to 4 |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Transport takes the byte |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of the burst |
| out_addr | output | 12 | Burst start register address |
| out_len | output | 3 | Burst length in bytes |
| cpl_valid | input | 1 | Transport completion |
| cpl_count | input | 3 | Bytes the sink acknowledged |
| done_valid | output | 1 | Outcome pulse |
| done_ok | output | 1 | Full-length acknowledgement |
| busy | output | 1 | A request is in progress |

## Verification
The assertions assume that the transport raises `cpl_valid` only after the final byte has been handed over. They also assume the lane count stays in the range 1 to 4, so that a burst is never empty or longer than five bytes. The stimulus respects both: a completion is pulsed only once the model has seen the last byte taken, and every request uses a lane count of 1, 2, 3 or 4. Within those limits, the bench applies back-pressure patterns and offers requests while the block is busy.

// File: rtl/train_wr_pkg.sv
package train_wr_pkg;
    typedef enum logic {
        REQ_SET_PAT   = 1'b0,
        REQ_UPD_LANES = 1'b1
    } req_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND   = 2'd1,
        ST_WAIT   = 2'd2,
        ST_REPORT = 2'd3
    } fmt_state_e;
endpackage

// File: rtl/train_wr_compose.sv
// Combinational burst composer: start address, length and ordered byte image.
module train_wr_compose
    import train_wr_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int BYTE_W    = 8,
    parameter int ADDR_W    = 12,
    parameter int PAT_ADDR  = 'h102,
    parameter int NARROW_W  = 2,
    parameter int WIDE_W    = 4,
    parameter int CNT_W     = 3,
    parameter int LEN_W     = 3
) (
    input  logic                        kind,
    input  logic                        clear,
    input  logic                        four_pat,
    input  logic [BYTE_W-1:0]           pattern,
    input  logic [LANES*BYTE_W-1:0]     lanes,
    input  logic [CNT_W-1:0]            lane_cnt,
    output logic [ADDR_W-1:0]           addr,
    output logic [LEN_W-1:0]            len,
    output logic [(LANES+1)*BYTE_W-1:0] seq
);
    localparam logic [BYTE_W-1:0] MASK_NARROW = BYTE_W'((1 << NARROW_W) - 1);
    localparam logic [BYTE_W-1:0] MASK_WIDE   = BYTE_W'((1 << WIDE_W) - 1);
    localparam logic [ADDR_W-1:0] LANE0_ADDR  = ADDR_W'(PAT_ADDR + 1);

    req_kind_e           kind_e;
    logic [BYTE_W-1:0]   field_mask;
    logic                pat_off;
    logic [LANES*BYTE_W-1:0] lane_eff;

    assign kind_e     = req_kind_e'(kind);
    assign field_mask = four_pat ? MASK_WIDE : MASK_NARROW;
    assign pat_off    = ((pattern & field_mask) == '0);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eff[g*BYTE_W +: BYTE_W] =
            (kind_e == REQ_SET_PAT && clear) ? '0 : lanes[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        unique case (kind_e)
            REQ_SET_PAT: begin
                addr = ADDR_W'(PAT_ADDR);
                seq  = {lane_eff, pattern};
                len  = pat_off ? LEN_W'(1) : LEN_W'(lane_cnt) + LEN_W'(1);
            end
            REQ_UPD_LANES: begin
                addr = LANE0_ADDR;
                seq  = {{BYTE_W{1'b0}}, lane_eff};
                len  = LEN_W'(lane_cnt);
            end
            default: begin
                addr = '0;
                seq  = '0;
                len  = '0;
            end
        endcase
    end
endmodule

// File: rtl/train_wr_pick.sv
// Selects one byte of the held burst image by index.
module train_wr_pick #(
    parameter int NBYTES = 5,
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic [NBYTES*BYTE_W-1:0] seq,
    input  logic [IDX_W-1:0]         idx,
    output logic [BYTE_W-1:0]        data
);
    always_comb begin
        data = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (idx == IDX_W'(i)) data = seq[i*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/train_wr_fmt.sv
module train_wr_fmt
    import train_wr_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int BYTE_W   = 8,
    parameter int ADDR_W   = 12,
    parameter int PAT_ADDR = 'h102,
    parameter int NARROW_W = 2,
    parameter int WIDE_W   = 4,
    localparam int NBYTES  = LANES + 1,
    localparam int CNT_W   = $clog2(LANES + 1),
    localparam int LEN_W   = $clog2(NBYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_kind,
    input  logic                    req_clear,
    input  logic                    req_four_pat,
    input  logic [BYTE_W-1:0]       req_pattern,
    input  logic [LANES*BYTE_W-1:0] req_lanes,
    input  logic [CNT_W-1:0]        req_lane_cnt,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [BYTE_W-1:0]       out_data,
    output logic                    out_last,
    output logic [ADDR_W-1:0]       out_addr,
    output logic [LEN_W-1:0]        out_len,
    input  logic                    cpl_valid,
    input  logic [LEN_W-1:0]        cpl_count,
    output logic                    done_valid,
    output logic                    done_ok,
    output logic                    busy
);
    fmt_state_e state_q, state_d;

    logic [ADDR_W-1:0]        addr_c, addr_q;
    logic [LEN_W-1:0]         len_c, len_q;
    logic [NBYTES*BYTE_W-1:0] seq_c, seq_q;
    logic [LEN_W-1:0]         idx_q;
    logic                     ok_q;
    logic                     accept;
    logic                     byte_go;
    logic                     at_last;

    train_wr_compose #(
        .LANES(LANES), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .PAT_ADDR(PAT_ADDR),
        .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
    ) compose_i (
        .kind(req_kind), .clear(req_clear), .four_pat(req_four_pat),
        .pattern(req_pattern), .lanes(req_lanes), .lane_cnt(req_lane_cnt),
        .addr(addr_c), .len(len_c), .seq(seq_c)
    );

    train_wr_pick #(.NBYTES(NBYTES), .BYTE_W(BYTE_W), .IDX_W(LEN_W)) pick_i (
        .seq(seq_q), .idx(idx_q), .data(out_data)
    );

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign byte_go = (state_q == ST_SEND) && out_ready;
    assign at_last = (idx_q == len_q - LEN_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid)          state_d = ST_SEND;
            ST_SEND:   if (out_ready && at_last) state_d = ST_WAIT;
            ST_WAIT:   if (cpl_valid)          state_d = ST_REPORT;
            ST_REPORT:                         state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // burst context: captured on acceptance, walked while sending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            len_q  <= '0;
            seq_q  <= '0;
            idx_q  <= '0;
            ok_q   <= 1'b0;
        end else begin
            if (accept) begin
                addr_q <= addr_c;
                len_q  <= len_c;
                seq_q  <= seq_c;
                idx_q  <= '0;
            end else if (byte_go && !at_last) begin
                idx_q <= idx_q + LEN_W'(1);
            end
            if (state_q == ST_WAIT && cpl_valid) ok_q <= (cpl_count == len_q);
        end
    end

    // outputs decoded from state
    always_comb begin
        req_ready  = 1'b0;
        out_valid  = 1'b0;
        done_valid = 1'b0;
        busy       = 1'b1;
        unique case (state_q)
            ST_IDLE:   begin req_ready = 1'b1; busy = 1'b0; end
            ST_SEND:   out_valid  = 1'b1;
            ST_WAIT:   ;
            ST_REPORT: done_valid = 1'b1;
            default:   ;
        endcase
    end

    assign out_last = out_valid && at_last;
    assign out_addr = addr_q;
    assign out_len  = len_q;
    assign done_ok  = done_valid && ok_q;
endmodule

// File: rtl/train_wr_chk.sv
module train_wr_chk #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 3,
    parameter int NBYTES = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BYTE_W-1:0] out_data,
    input logic              out_last,
    input logic [ADDR_W-1:0] out_addr,
    input logic [LEN_W-1:0]  out_len,
    input logic              cpl_valid,
    input logic [LEN_W-1:0]  cpl_count,
    input logic              done_valid,
    input logic              done_ok,
    input logic              busy
);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
            $stable(out_last) && $stable(out_addr) && $stable(out_len)));

    assert_len_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len != '0 && out_len <= LEN_W'(NBYTES)));

    assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    assert_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_ok == ($past(cpl_valid) && $past(cpl_count) == out_len)));

    assert_no_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!out_valid && !done_valid));

    assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    assert_report_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> busy);
endmodule

bind train_wr_fmt train_wr_chk #(
    .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .NBYTES(NBYTES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_addr(out_addr), .out_len(out_len),
    .cpl_valid(cpl_valid), .cpl_count(cpl_count), .done_valid(done_valid),
    .done_ok(done_ok), .busy(busy)
);

// File: tb/train_wr_fmt_tb.sv
`timescale 1ns/1ps
module train_wr_fmt_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_kind = 1'b0;
    logic        req_clear = 1'b0;
    logic        req_four_pat = 1'b0;
    logic [7:0]  req_pattern = '0;
    logic [31:0] req_lanes = '0;
    logic [2:0]  req_lane_cnt = 3'd1;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        out_last;
    logic [11:0] out_addr;
    logic [2:0]  out_len;
    logic        cpl_valid = 1'b0;
    logic [2:0]  cpl_count = '0;
    logic        done_valid;
    logic        done_ok;
    logic        busy;

    always #2 clk = ~clk;

    train_wr_fmt dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_clear(req_clear), .req_four_pat(req_four_pat),
        .req_pattern(req_pattern), .req_lanes(req_lanes), .req_lane_cnt(req_lane_cnt),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .out_addr(out_addr), .out_len(out_len),
        .cpl_valid(cpl_valid), .cpl_count(cpl_count), .done_valid(done_valid),
        .done_ok(done_ok), .busy(busy)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    // behavioural reference: phase 0 idle, 1 streaming, 2 awaiting completion, 3 outcome
    int          m_phase = 0;
    logic [7:0]  m_q[$];
    int          m_len = 0;
    logic [11:0] m_addr = '0;
    bit          m_ok = 0;
    string       m_tag = "R1";

    task automatic cmp(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_phase = 0;
            m_q.delete();
        end else begin
            case (m_phase)
                0: if (req_valid) begin
                    m_q.delete();
                    if (req_kind == 1'b0) begin
                        m_addr = 12'h102;
                        m_q.push_back(req_pattern);
                        if ((req_pattern & (req_four_pat ? 8'h0F : 8'h03)) != 0)
                            for (int i = 0; i < req_lane_cnt; i++)
                                m_q.push_back(req_clear ? 8'h00 : req_lanes[8*i +: 8]);
                    end else begin
                        m_addr = 12'h103;
                        for (int i = 0; i < req_lane_cnt; i++)
                            m_q.push_back(req_lanes[8*i +: 8]);
                    end
                    m_len = m_q.size();
                    m_phase = 1;
                end
                1: if (out_ready) begin
                    void'(m_q.pop_front());
                    if (m_q.size() == 0) m_phase = 2;
                end
                2: if (cpl_valid) begin
                    m_ok = (cpl_count == 3'(m_len));
                    m_phase = 3;
                end
                default: m_phase = 0;
            endcase
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            cmp("R9 busy", busy, m_phase != 0);
            cmp("R7 req_ready", req_ready, m_phase == 0);
            cmp("R7 out_valid", out_valid, m_phase == 1);
            cmp("R6 done_valid", done_valid, m_phase == 3);
            if (m_phase == 1) begin
                cmp({m_tag, " out_data"}, out_data, m_q[0]);
                cmp("R8 out_last", out_last, m_q.size() == 1);
                cmp({m_tag, " out_addr"}, out_addr, m_addr);
                cmp({m_tag, " out_len"}, out_len, m_len);
            end
            if (m_phase == 3) cmp("R6 done_ok", done_ok, m_ok);
        end
    end

    task automatic summary();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 20000 && !finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    // one request end to end; stall picks back-pressure, ack is the completion count
    task automatic run(input string tag, input bit kind, input bit clr, input bit four,
                       input logic [7:0] pat, input logic [31:0] lanes, input int cnt,
                       input int stall, input int ack_delta, input bit poke);
        @(posedge clk); #1;
        m_tag = tag;
        req_kind = kind; req_clear = clr; req_four_pat = four;
        req_pattern = pat; req_lanes = lanes; req_lane_cnt = 3'(cnt);
        req_valid = 1'b1;
        @(posedge clk); #1;
        // R7: a second request while busy must be ignored
        req_valid = poke;
        req_pattern = 8'hFF; req_lanes = 32'hDEADBEEF; req_kind = ~kind;
        for (int k = 0; m_phase == 1; k++) begin
            out_ready = (stall == 0) ? 1'b1 : ((k % stall) == stall - 1);
            @(posedge clk); #1;
        end
        out_ready = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        cpl_count = 3'(m_len + ack_delta);
        cpl_valid = 1'b1;
        @(posedge clk); #1;
        cpl_valid = 1'b0;
        req_valid = 1'b0;
        while (m_phase != 0) begin @(posedge clk); #1; end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        cmp("R1 busy", busy, 0);
        cmp("R1 req_ready", req_ready, 1);
        cmp("R1 out_valid", out_valid, 0);
        cmp("R1 done_valid", done_valid, 0);
        rst_n = 1'b1;
        // R2: set-pattern, 4 lanes, no stall, full ack
        run("R2", 0, 0, 0, 8'h21, 32'h44332211, 4, 0, 0, 0);
        // R2: 2 lanes with back-pressure, R8 hold checked each stall cycle
        run("R2", 0, 0, 0, 8'h22, 32'hA4A3A2A1, 2, 3, 0, 1);
        // R2: 3 lanes, short ack -> done_ok=0 (R6)
        run("R2", 0, 0, 0, 8'h01, 32'h0C0B0A09, 3, 2, -1, 0);
        // R3: field zero with scramble-off bit set -> one byte
        run("R3", 0, 0, 0, 8'h20, 32'h11111111, 4, 0, 0, 1);
        // R3: 0x04 is off under the narrow field
        run("R3", 0, 0, 0, 8'h04, 32'h55667788, 2, 2, 0, 0);
        // R3: 0x04 is a live pattern under the wide field
        run("R3", 0, 0, 1, 8'h04, 32'h55667788, 2, 0, 0, 0);
        // R3: 0x30 is off under the wide field
        run("R3", 0, 0, 1, 8'h30, 32'h99999999, 4, 0, 0, 0);
        // R4: update-lanes, 4 and 1 lanes
        run("R4", 1, 0, 0, 8'h21, 32'hF4F3F2F1, 4, 2, 0, 1);
        run("R4", 1, 0, 0, 8'h21, 32'h000000E7, 1, 0, 0, 0);
        // R5: clear lanes on set-pattern; no effect on update-lanes
        run("R5", 0, 1, 0, 8'h21, 32'h87654321, 4, 0, 0, 0);
        run("R5", 1, 1, 0, 8'h00, 32'h87654321, 3, 0, 0, 0);
        // R6: over-count ack is also a failure
        run("R6", 0, 0, 0, 8'h02, 32'h04030201, 1, 0, 1, 0);
        repeat (4) @(posedge clk);
        summary();
    end
endmodule